// File: doc/BRIEF.md
# Three-Wire Serial Control Register Target

This block is the serial target for one 8-bit control register. A host talks to it over three wires: a serial clock, an active-low select, and one data line that carries bits in both directions. Each transaction is 24 bits long. It carries a direction flag, a 15-bit register address and a single data byte. A write to the implemented address replaces the register contents. A read sends the register contents back on the same data line, so the block takes over the line once the address has been received.

The serial pins are treated as asynchronous. They pass through a synchronizer into the system clock domain, and all frame handling works on edges found there. The tri-state buffer itself sits outside the block: the block gives a data value and an output-enable for the pad, and it reads the pad's input value. The register value is available on a parallel output for downstream logic.

Top module: `spi3w_slave`

## Requirements
- R1: A frame is sent most significant bit first as a direction flag (1 = read, 0 = write), then address bits 14 down to 0, then data bits 7 down to 0. Each bit is taken on a rising serial-clock edge. A frame with the flag at 1 never changes the register.
- R2: A write frame to address 0x100 loads its data byte into the control register once the 24th bit has been taken.
- R3: A write frame to any address other than 0x100 leaves the register unchanged.
- R4: A frame ended by select going high before the 24th rising edge is discarded. The next frame is decoded from its own first bit.
- R5: In a read of address 0x100, the block presents bit 7 of the register after the falling edge that follows the 16th rising edge, and one lower bit after each later falling edge. The output-enable is high only from that first falling edge up to the falling edge that follows the 24th rising edge.
- R6: A read of any address other than 0x100 returns 0x00.
- R7: While select is high, the output-enable is low. This includes a select deassertion in the middle of a read.
- R8: After reset the register holds 0x00 and the output-enable is low.
- R9: Rising edges after the 24th in the same frame are ignored. They neither shift nor change the register.
- R10: Every effect of a pin edge appears at the outputs exactly SYNC_STAGES+1 system clock cycles after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host, asynchronous |
| ser_sel_n | input | 1 | Active-low frame select, asynchronous |
| ser_dat_i | input | 1 | Value seen on the shared data line |
| ser_dat_o | output | 1 | Value driven onto the shared data line |
| ser_dat_oe | output | 1 | High when the block drives the shared data line |
| ctrl_q | output | 8 | Current control register value |

## Verification
The assertions assume the host keeps each serial-clock level for at least two system clock cycles, so the synchronized copy shows every edge. They also assume select and the serial clock never change on the same sample, and that the clock idles low around select transitions. The stimulus holds each clock level for four system cycles and surrounds every select change with idle cycles in which the clock stays low. Because of this, edge detection, bit counting and the data-line turnaround are always observed in the order the frame defines.

// File: rtl/spi3w_pkg.sv
// Shared definitions for the three-wire serial register target.
// Assumes nothing beyond a standard SystemVerilog compile order.
package spi3w_pkg;
    localparam int ADDR_W_DEF = 15;
    localparam int DATA_W_DEF = 8;

    // Position of the bit counter within a frame.
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_t;
endpackage

// File: rtl/spi3w_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes each pin is independent and slow enough to tolerate STAGES cycles of delay.
module spi3w_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop when one stage is requested.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= RESET_VAL;
                else        stage_q <= din;
            end
        end else begin : g_chain
            // Shift the pin values along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
                else        stage_q <= {stage_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi3w_frame.sv
// Frame receiver: detects serial-clock edges, counts bits, shifts in the header
// and data, and produces single-cycle header and write strobes.
// Assumes synchronized inputs and clock levels held at least two cycles.
module spi3w_frame
    import spi3w_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int DATA_W    = DATA_W_DEF,
    parameter int HDR_LEN   = 1 + ADDR_W,
    parameter int FRAME_LEN = HDR_LEN + DATA_W,
    parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sck_s,
    input  logic              din_s,
    output logic              cs_active,
    output logic              sck_fall,
    output phase_t            phase,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              hdr_stb,
    output logic              cur_rd,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              hdr_rd_q,
    output logic [ADDR_W-1:0] hdr_addr_q,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data
);
    localparam int SH_W = ADDR_W;

    logic            sck_q;
    logic            sck_rise;
    logic            take_bit;
    logic [SH_W-1:0] shift_q;

    assign cs_active = !sel_n_s;
    assign sck_rise  = cs_active && sck_s && !sck_q;
    assign sck_fall  = cs_active && !sck_s && sck_q;
    assign take_bit  = sck_rise && (bit_cnt != CNT_W'(FRAME_LEN));

    // Remember the previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Count bits taken in the current frame, saturating at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)         bit_cnt <= '0;
        else if (!cs_active) bit_cnt <= '0;
        else if (take_bit)   bit_cnt <= bit_cnt + 1'b1;
    end

    // Shift each received bit in, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (take_bit) shift_q <= {shift_q[SH_W-2:0], din_s};
    end

    assign cur_rd   = shift_q[SH_W-1];
    assign cur_addr = {shift_q[ADDR_W-2:0], din_s};
    assign hdr_stb  = sck_rise && (bit_cnt == CNT_W'(HDR_LEN - 1));
    assign wr_stb   = sck_rise && (bit_cnt == CNT_W'(FRAME_LEN - 1)) && !hdr_rd_q;
    assign wr_data  = {shift_q[DATA_W-2:0], din_s};

    // Hold the decoded direction and address for the rest of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            hdr_rd_q   <= 1'b0;
            hdr_addr_q <= '0;
        end else if (hdr_stb) begin
            hdr_rd_q   <= cur_rd;
            hdr_addr_q <= cur_addr;
        end
    end

    // Classify the counter into frame phases.
    always_comb begin
        if (bit_cnt < CNT_W'(HDR_LEN))        phase = PH_HDR;
        else if (bit_cnt < CNT_W'(FRAME_LEN)) phase = PH_DATA;
        else                                  phase = PH_DONE;
    end
endmodule

// File: rtl/spi3w_ctrlreg.sv
// Control register with single-address decode for writes and readback.
// Assumes wr_stb is a one-cycle pulse issued only for complete write frames.
module spi3w_ctrlreg #(
    parameter int                ADDR_W   = 15,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] reg_q
);
    logic wr_hit;

    assign wr_hit = wr_stb && (wr_addr == REG_ADDR);

    // Load the register only for a write that hits the implemented address.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_q <= '0;
        else if (wr_hit) reg_q <= wr_data;
    end

    // Unimplemented addresses read as zero.
    assign rd_data = (rd_addr == REG_ADDR) ? reg_q : '0;
endmodule

// File: rtl/spi3w_tx.sv
// Read-data shifter and line turnaround: loads the byte at header end and
// drives one bit per falling edge during the data phase of a read frame.
// Assumes load and sck_fall never occur in the same cycle.
module spi3w_tx
    import spi3w_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              sck_fall,
    input  phase_t            phase,
    input  logic              read_mode,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              dout,
    output logic              dout_oe
);
    logic [DATA_W-1:0] shift_q;

    // Capture the read byte when the header of a read frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                shift_q <= '0;
        else if (load)             shift_q <= load_data;
        else if (sck_fall && read_mode && phase == PH_DATA)
                                   shift_q <= {shift_q[DATA_W-2:0], 1'b0};
    end

    // Drive the line in the data phase of a read; release it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (!cs_active) begin
            dout_oe <= 1'b0;
        end else if (sck_fall) begin
            if (read_mode && phase == PH_DATA) begin
                dout    <= shift_q[DATA_W-1];
                dout_oe <= 1'b1;
            end else begin
                dout_oe <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi3w_slave.sv
// Top of the three-wire serial register target. Synchronizes the pins, decodes
// 24-bit frames, holds the control register and turns the data line around.
// Assumes an external pad combines ser_dat_o/ser_dat_oe/ser_dat_i into one wire.
module spi3w_slave
    import spi3w_pkg::*;
#(
    parameter int                ADDR_W      = ADDR_W_DEF,
    parameter int                DATA_W      = DATA_W_DEF,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 'h100,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_sel_n,
    input  logic              ser_dat_i,
    output logic              ser_dat_o,
    output logic              ser_dat_oe,
    output logic [DATA_W-1:0] ctrl_q
);
    localparam int HDR_LEN   = 1 + ADDR_W;
    localparam int FRAME_LEN = HDR_LEN + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    logic              sel_n_s, sck_s, din_s;
    logic              cs_active, sck_fall, hdr_stb, cur_rd, hdr_rd_q, wr_stb;
    logic [ADDR_W-1:0] cur_addr, hdr_addr_q;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [CNT_W-1:0]  bit_cnt;
    phase_t            phase;

    spi3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_sel_n, ser_clk, ser_dat_i}),
        .dout  ({sel_n_s, sck_s, din_s})
    );

    spi3w_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_s    (sel_n_s),
        .sck_s      (sck_s),
        .din_s      (din_s),
        .cs_active  (cs_active),
        .sck_fall   (sck_fall),
        .phase      (phase),
        .bit_cnt    (bit_cnt),
        .hdr_stb    (hdr_stb),
        .cur_rd     (cur_rd),
        .cur_addr   (cur_addr),
        .hdr_rd_q   (hdr_rd_q),
        .hdr_addr_q (hdr_addr_q),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data)
    );

    spi3w_ctrlreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (hdr_addr_q),
        .wr_data (wr_data),
        .rd_addr (cur_addr),
        .rd_data (rd_data),
        .reg_q   (ctrl_q)
    );

    spi3w_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .sck_fall  (sck_fall),
        .phase     (phase),
        .read_mode (hdr_rd_q),
        .load      (hdr_stb && cur_rd),
        .load_data (rd_data),
        .dout      (ser_dat_o),
        .dout_oe   (ser_dat_oe)
    );
endmodule

// File: rtl/spi3w_checker.sv
// Protocol checker for spi3w_slave, attached by bind.
// Assumes serial-clock levels last at least two system cycles.
module spi3w_checker #(
    parameter int                ADDR_W   = 15,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h100,
    parameter int                CNT_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_active,
    input logic              oe,
    input logic              hdr_rd_q,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] ctrl_q
);
    localparam int HDR_LEN   = 1 + ADDR_W;
    localparam int FRAME_LEN = HDR_LEN + DATA_W;

    // Deselect releases the data line on the next cycle.
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> !oe);

    // The line is driven only after the header of a read frame.
    assert_drive_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (hdr_rd_q && bit_cnt >= CNT_W'(HDR_LEN)));

    // A write to another address leaves the register alone.
    assert_foreign_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr != REG_ADDR) |=> $stable(ctrl_q));

    // The register changes only after a matching complete write.
    assert_reg_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(wr_stb && wr_addr == REG_ADDR));

    // The bit counter never passes the frame length.
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_LEN));
endmodule

bind spi3w_slave spi3w_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_active (cs_active),
    .oe        (ser_dat_oe),
    .hdr_rd_q  (hdr_rd_q),
    .bit_cnt   (bit_cnt),
    .wr_stb    (wr_stb),
    .wr_addr   (hdr_addr_q),
    .ctrl_q    (ctrl_q)
);

// File: tb/tb_spi3w_slave.sv
`timescale 1ns/100ps
module tb_spi3w_slave;
    localparam int LAT = 3;   // SYNC_STAGES + 1
    localparam int H   = 4;   // system cycles per serial-clock level

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic sdo, oe;
    logic [7:0] ctrl;

    spi3w_slave dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(sck), .ser_sel_n(cs_n),
        .ser_dat_i(sdi), .ser_dat_o(sdo), .ser_dat_oe(oe), .ctrl_q(ctrl)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    string req_tag = "R8";

    // Behavioural reference state
    int         m_cnt = 0;
    logic [23:0] m_sh = '0;
    logic       m_rd = 1'b0;
    logic [14:0] m_addr = '0;
    logic [7:0] m_reg = '0, m_rbyte = '0;
    logic       m_oe = 1'b0, m_sdo = 1'b0;
    logic       p_sck = 1'b0;
    logic [7:0] h_reg [LAT];
    logic       h_oe  [LAT];
    logic       h_sdo [LAT];
    logic       last_oe, last_sdo;

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
        end
    endtask

    task automatic model(input logic c, input logic s, input logic d);
        if (c) begin
            m_cnt = 0; m_oe = 1'b0;
        end else begin
            if (!p_sck && s && m_cnt < 24) begin
                m_sh = {m_sh[22:0], d};
                m_cnt++;
                if (m_cnt == 16) begin
                    m_rd = m_sh[15]; m_addr = m_sh[14:0];
                    m_rbyte = (m_addr == 15'h100) ? m_reg : 8'h00;
                end
                if (m_cnt == 24 && !m_rd && m_addr == 15'h100) m_reg = m_sh[7:0];
            end
            if (p_sck && !s) begin
                if (m_rd && m_cnt >= 16 && m_cnt < 24) begin
                    m_oe = 1'b1; m_sdo = m_rbyte[7 - (m_cnt - 16)];
                end else begin
                    m_oe = 1'b0;
                end
            end
        end
        p_sck = s;
    endtask

    // One system cycle: compare against the delayed model, then drive pins.
    task automatic step(input logic c, input logic s, input logic d);
        @(negedge clk);
        last_oe = oe; last_sdo = sdo;
        if (rst_n) begin
            chk({req_tag, " reg"}, ctrl, h_reg[LAT-1]);
            chk({req_tag, " oe"}, oe, h_oe[LAT-1]);
            if (h_oe[LAT-1]) chk({req_tag, " dat"}, sdo, h_sdo[LAT-1]);
        end
        for (int i = LAT - 1; i > 0; i--) begin
            h_reg[i] = h_reg[i-1]; h_oe[i] = h_oe[i-1]; h_sdo[i] = h_sdo[i-1];
        end
        cs_n = c; sck = s; sdi = d;
        model(c, s, d);
        h_reg[0] = m_reg; h_oe[0] = m_oe; h_sdo[0] = m_sdo;
    endtask

    task automatic frame(input logic rw, input logic [14:0] a, input logic [7:0] dat,
                         input int nbits, output logic [7:0] rb, output logic oe_early);
        logic [23:0] word;
        logic bv;
        word = {rw, a, dat};
        rb = '0; oe_early = 1'b0;
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        for (int b = 0; b < nbits; b++) begin
            bv = (b < 24) ? word[23-b] : 1'b1;
            for (int i = 0; i < H; i++) step(1'b0, 1'b0, bv);
            step(1'b0, 1'b1, bv);
            if (b == 15) oe_early = last_oe;
            if (b >= 16 && b < 24) rb = {rb[6:0], last_sdo};
            for (int i = 1; i < H; i++) step(1'b0, 1'b1, bv);
        end
        for (int i = 0; i < H; i++) step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] rb;
        logic oe0;
        for (int i = 0; i < LAT; i++) begin
            h_reg[i] = '0; h_oe[i] = 1'b0; h_sdo[i] = 1'b0;
        end
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
        chk("R8 reset reg", ctrl, 8'h00);
        chk("R8 reset oe", oe, 0);

        req_tag = "R2";
        frame(1'b0, 15'h100, 8'hA5, 24, rb, oe0);
        chk("R2 write", ctrl, 8'hA5);

        req_tag = "R5";
        frame(1'b1, 15'h100, 8'h00, 24, rb, oe0);
        chk("R5 readback", rb, 8'hA5);
        chk("R5 no drive in header", oe0, 0);
        chk("R1 read keeps reg", ctrl, 8'hA5);

        req_tag = "R1";
        frame(1'b1, 15'h100, 8'h3C, 24, rb, oe0);
        chk("R1 read flag no write", ctrl, 8'hA5);

        req_tag = "R3";
        frame(1'b0, 15'h101, 8'hFF, 24, rb, oe0);
        chk("R3 addr 0x101", ctrl, 8'hA5);
        frame(1'b0, 15'h4100, 8'hFF, 24, rb, oe0);
        chk("R3 addr 0x4100", ctrl, 8'hA5);
        frame(1'b0, 15'h000, 8'h11, 24, rb, oe0);
        chk("R3 addr 0x000", ctrl, 8'hA5);

        req_tag = "R6";
        frame(1'b1, 15'h0FF, 8'h00, 24, rb, oe0);
        chk("R6 read 0x0FF", rb, 8'h00);
        frame(1'b1, 15'h4100, 8'h00, 24, rb, oe0);
        chk("R6 read 0x4100", rb, 8'h00);

        req_tag = "R4";
        frame(1'b0, 15'h100, 8'h00, 23, rb, oe0);
        chk("R4 cut at 23", ctrl, 8'hA5);
        frame(1'b0, 15'h100, 8'h00, 10, rb, oe0);
        chk("R4 cut at 10", ctrl, 8'hA5);
        frame(1'b0, 15'h100, 8'h69, 24, rb, oe0);
        chk("R4 next frame clean", ctrl, 8'h69);

        req_tag = "R7";
        frame(1'b1, 15'h100, 8'h00, 19, rb, oe0);
        chk("R7 released after deselect", oe, 0);

        req_tag = "R9";
        frame(1'b0, 15'h100, 8'h5A, 30, rb, oe0);
        chk("R9 extra bits ignored", ctrl, 8'h5A);
        frame(1'b1, 15'h100, 8'h00, 30, rb, oe0);
        chk("R9 read after long frame", rb, 8'h5A);
        chk("R9 released", oe, 0);

        req_tag = "R10";
        frame(1'b0, 15'h100, 8'hC3, 24, rb, oe0);
        chk("R10 write timing", ctrl, 8'hC3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule